// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the directory logic that sits at the home node of a distributed shared-memory machine. For each line of the memory attached to that node it keeps a coherence state and a presence vector of the nodes that currently hold a copy. Nodes send it a request when they miss on a line or want to write a line they only hold as a reader. The directory sends commands only to the nodes its entry names. Invalidates go to the readers. A forwarded request goes to the owner of a dirty line. The reply tells the requester where its data or permission comes from. Acknowledgements from the nodes that received commands close the transaction and update the entry.

All traffic uses valid/ready handshakes tagged with node IDs. One request is accepted per cycle when the outbound port is free. Outbound messages leave one per cycle. One transaction at a time may wait for acknowledgements. While it waits, its line is busy, and other work that needs no acknowledgements carries on. The network, the memory array and the caches are outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is Uncached, `req_ready` is 1 and `msg_valid` is 0. Message kinds on `msg_kind` are: 0 data reply from memory, 1 ownership grant without data, 2 invalidate, 3 forwarded read, 4 forwarded write, 5 retry.
- R2: A read (`req_wr`=0) to an Uncached or Shared line gets one kind-0 message to the requester. The line then becomes Shared with the requester added to its presence vector.
- R3: A write/upgrade (`req_wr`=1) to an Uncached line gets one kind-0 message to the requester. The requester becomes the Exclusive owner.
- R4: A write to a Shared line that has readers other than the requester sends one kind-2 message to each of those readers, in ascending node order. It never sends one to the requester, and `msg_req` carries the requester's ID.
- R5: After the invalidates of R4, the requester receives nothing until every invalidated node has acknowledged. Then it receives kind 1 if it held a shared copy, otherwise kind 0, and becomes the Exclusive owner.
- R6: A write to a Shared line whose only reader is the requester gets an immediate kind-1 message, and the requester becomes the owner.
- R7: A read to a line owned Exclusive by another node sends kind 3 to the owner, with `msg_req` set to the requester. Once the owner acknowledges, the line is Shared by exactly the old owner and the requester.
- R8: A write to a line owned by another node sends kind 4 to the owner. Once the owner acknowledges, the requester is the sole Exclusive owner.
- R9: A request from the owner of an Exclusive line gets kind 1 for a write or kind 0 for a read, and the entry is unchanged.
- R10: A request to a line whose transaction is still waiting for acknowledgements gets a kind-5 message to the requester, and the entry is unchanged.
- R11: While one transaction waits, a request to another line that would itself need acknowledgements gets kind 5. Requests that need none are served normally.
- R12: While `msg_valid` is high and `msg_ready` low, the message fields hold steady and `req_ready` is 0.
- R13: An acknowledgement for a line that is not waiting, or from a node that is not awaited, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_src | input | NW | Requesting node |
| req_line | input | LW | Line index |
| req_wr | input | 1 | 1 write/upgrade, 0 read miss |
| ack_valid | input | 1 | Acknowledgement present (always taken) |
| ack_src | input | NW | Acknowledging node |
| ack_line | input | LW | Line being acknowledged |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Network takes the message |
| msg_dst | output | NW | Destination node |
| msg_kind | output | 3 | Message kind code (see R1) |
| msg_line | output | LW | Line index |
| msg_req | output | NW | Original requester |

## Verification
The hardest situation to reach is a line left half-acknowledged while unrelated traffic keeps flowing. The bench first builds a line with two readers and lets a third node write to it. With those invalidates outstanding, it sends a request to the busy line and requests to another line that need no acknowledgements and that need one. It also sends stray acknowledgements from a node that is not awaited and for the wrong line. Only then does it supply the real acknowledgements one at a time and check that the grant appears after the last one and not before. A long pseudo-random sweep over four nodes and four lines then runs every state and request combination against an arithmetic model. In that sweep, acknowledgements are supplied and busy-line retries are injected whenever a transaction opens.

// File: rtl/dir_home_pkg.sv
`timescale 1ns/1ps
package dir_home_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dstate_e;

   typedef enum logic [2:0] {
      MK_DATA   = 3'd0,
      MK_GRANT  = 3'd1,
      MK_INV    = 3'd2,
      MK_FWD_RD = 3'd3,
      MK_FWD_WR = 3'd4,
      MK_RETRY  = 3'd5
   } mkind_e;

   typedef enum logic [1:0] {
      PK_RD_FWD = 2'd0,
      PK_WR_FWD = 2'd1,
      PK_WR_INV = 2'd2
   } pkind_e;
endpackage

// File: rtl/dir_entry_store.sv
`timescale 1ns/1ps
module dir_entry_store import dir_home_pkg::*; #(
   parameter int NODES = 4,
   parameter int LINES = 16,
   localparam int NW = $clog2(NODES),
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    rd_line,
   output dstate_e          rd_state,
   output logic [NODES-1:0] rd_vec,
   output logic [NW-1:0]    rd_owner,
   input  logic             wr_en,
   input  logic [LW-1:0]    wr_line,
   input  dstate_e          wr_state,
   input  logic [NODES-1:0] wr_vec,
   input  logic [NW-1:0]    wr_owner
);
   dstate_e          st_all  [LINES];
   logic [NODES-1:0] vec_all [LINES];
   logic [NW-1:0]    own_all [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      dstate_e          st_q;
      logic [NODES-1:0] vec_q;
      logic [NW-1:0]    own_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= DS_UNC;
            vec_q <= '0;
            own_q <= '0;
         end else if (wr_en && wr_line == LW'(i)) begin
            st_q  <= wr_state;
            vec_q <= wr_vec;
            own_q <= wr_owner;
         end
      end
      assign st_all[i]  = st_q;
      assign vec_all[i] = vec_q;
      assign own_all[i] = own_q;
   end

   assign rd_state = st_all[rd_line];
   assign rd_vec   = vec_all[rd_line];
   assign rd_owner = own_all[rd_line];
endmodule

// File: rtl/dir_msg_emitter.sv
`timescale 1ns/1ps
module dir_msg_emitter import dir_home_pkg::*; #(
   parameter int NODES = 4,
   parameter int LINES = 16,
   parameter bit ASCENDING = 1'b1,
   localparam int NW = $clog2(NODES),
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NODES-1:0] ld_mask,
   input  mkind_e           ld_kind,
   input  logic [LW-1:0]    ld_line,
   input  logic [NW-1:0]    ld_req,
   output logic             idle,
   output logic             msg_valid,
   input  logic             msg_ready,
   output logic [NW-1:0]    msg_dst,
   output mkind_e           msg_kind,
   output logic [LW-1:0]    msg_line,
   output logic [NW-1:0]    msg_req
);
   logic [NODES-1:0] mask_q;
   mkind_e           kind_q;
   logic [LW-1:0]    line_q;
   logic [NW-1:0]    req_q;
   logic [NW-1:0]    pick;

   if (ASCENDING) begin : g_low_first
      always_comb begin
         pick = '0;
         for (int i = NODES - 1; i >= 0; i--)
            if (mask_q[i]) pick = NW'(i);
      end
   end else begin : g_high_first
      always_comb begin
         pick = '0;
         for (int i = 0; i < NODES; i++)
            if (mask_q[i]) pick = NW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         kind_q <= MK_DATA;
         line_q <= '0;
         req_q  <= '0;
      end else if (load) begin
         mask_q <= ld_mask;
         kind_q <= ld_kind;
         line_q <= ld_line;
         req_q  <= ld_req;
      end else if (msg_valid && msg_ready) begin
         mask_q[pick] <= 1'b0;
      end
   end

   assign idle      = (mask_q == '0);
   assign msg_valid = !idle;
   assign msg_dst   = pick;
   assign msg_kind  = kind_q;
   assign msg_line  = line_q;
   assign msg_req   = req_q;
endmodule

// File: rtl/dir_ack_tracker.sv
`timescale 1ns/1ps
module dir_ack_tracker import dir_home_pkg::*; #(
   parameter int NODES = 4,
   parameter int LINES = 16,
   localparam int NW = $clog2(NODES),
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LW-1:0]    st_line,
   input  logic [NW-1:0]    st_req,
   input  logic [NW-1:0]    st_owner,
   input  pkind_e           st_kind,
   input  logic [NODES-1:0] st_wait,
   input  logic             st_had,
   input  logic             ack_valid,
   input  logic [NW-1:0]    ack_src,
   input  logic [LW-1:0]    ack_line,
   input  logic             finish,
   output logic             busy,
   output logic [LW-1:0]    p_line,
   output logic [NW-1:0]    p_req,
   output logic [NW-1:0]    p_owner,
   output pkind_e           p_kind,
   output logic             p_had,
   output logic [NODES-1:0] p_wait,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         p_line  <= '0;
         p_req   <= '0;
         p_owner <= '0;
         p_kind  <= PK_WR_INV;
         p_had   <= 1'b0;
         p_wait  <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         p_line  <= st_line;
         p_req   <= st_req;
         p_owner <= st_owner;
         p_kind  <= st_kind;
         p_had   <= st_had;
         p_wait  <= st_wait;
      end else if (finish) begin
         busy    <= 1'b0;
      end else if (busy && ack_valid && ack_line == p_line) begin
         p_wait[ack_src] <= 1'b0;
      end
   end

   assign done = busy && (p_wait == '0);
endmodule

// File: rtl/dir_home_ctrl.sv
`timescale 1ns/1ps
module dir_home_ctrl import dir_home_pkg::*; #(
   parameter int NODES = 4,
   parameter int LINES = 16,
   localparam int NW = $clog2(NODES),
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [NW-1:0] req_src,
   input  logic [LW-1:0] req_line,
   input  logic          req_wr,
   input  logic          ack_valid,
   input  logic [NW-1:0] ack_src,
   input  logic [LW-1:0] ack_line,
   output logic          msg_valid,
   input  logic          msg_ready,
   output logic [NW-1:0] msg_dst,
   output logic [2:0]    msg_kind,
   output logic [LW-1:0] msg_line,
   output logic [NW-1:0] msg_req
);
   if (NODES < 2 || (1 << NW) != NODES) begin : g_bad_nodes
      $error("dir_home_ctrl: NODES must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << LW) != LINES) begin : g_bad_lines
      $error("dir_home_ctrl: LINES must be a power of two of at least 2");
   end

   function automatic logic [NODES-1:0] node_bit(input logic [NW-1:0] n);
      node_bit    = '0;
      node_bit[n] = 1'b1;
   endfunction

   // directory entry storage
   dstate_e          rd_state;
   logic [NODES-1:0] rd_vec;
   logic [NW-1:0]    rd_owner;
   logic             wr_en;
   logic [LW-1:0]    wr_line;
   dstate_e          wr_state;
   logic [NODES-1:0] wr_vec;
   logic [NW-1:0]    wr_owner;

   // outbound message emitter
   logic             em_load;
   logic [NODES-1:0] em_mask;
   mkind_e           em_kind;
   logic [NW-1:0]    em_req;
   logic [LW-1:0]    em_line;
   logic             em_idle;
   mkind_e           out_kind;

   // pending transaction slot
   logic             trk_start;
   pkind_e           trk_st_kind;
   logic [NODES-1:0] trk_st_wait;
   logic [NW-1:0]    trk_st_owner;
   logic             trk_finish;
   logic             trk_busy;
   logic [LW-1:0]    trk_line;
   logic [NW-1:0]    trk_req;
   logic [NW-1:0]    trk_owner;
   pkind_e           trk_kind;
   logic             trk_had;
   logic [NODES-1:0] trk_wait;
   logic             trk_done;

   logic             accept;
   logic             line_busy;
   logic [NODES-1:0] others;
   logic [NODES-1:0] req_bit;

   dir_entry_store #(.NODES(NODES), .LINES(LINES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_line(req_line), .rd_state(rd_state), .rd_vec(rd_vec), .rd_owner(rd_owner),
      .wr_en(wr_en), .wr_line(wr_line), .wr_state(wr_state),
      .wr_vec(wr_vec), .wr_owner(wr_owner)
   );

   dir_msg_emitter #(.NODES(NODES), .LINES(LINES), .ASCENDING(1'b1)) u_emit (
      .clk(clk), .rst_n(rst_n),
      .load(em_load), .ld_mask(em_mask), .ld_kind(em_kind),
      .ld_line(em_line), .ld_req(em_req), .idle(em_idle),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dst(msg_dst),
      .msg_kind(out_kind), .msg_line(msg_line), .msg_req(msg_req)
   );

   dir_ack_tracker #(.NODES(NODES), .LINES(LINES)) u_track (
      .clk(clk), .rst_n(rst_n),
      .start(trk_start), .st_line(req_line), .st_req(req_src),
      .st_owner(trk_st_owner), .st_kind(trk_st_kind), .st_wait(trk_st_wait),
      .st_had(rd_vec[req_src]),
      .ack_valid(ack_valid), .ack_src(ack_src), .ack_line(ack_line),
      .finish(trk_finish), .busy(trk_busy), .p_line(trk_line), .p_req(trk_req),
      .p_owner(trk_owner), .p_kind(trk_kind), .p_had(trk_had),
      .p_wait(trk_wait), .done(trk_done)
   );

   assign msg_kind   = out_kind;
   assign req_ready  = em_idle && !trk_done;
   assign accept     = req_valid && req_ready;
   assign trk_finish = trk_done && em_idle;
   assign line_busy  = trk_busy && (trk_line == req_line);
   assign req_bit    = node_bit(req_src);
   assign others     = rd_vec & ~req_bit;

   always_comb begin
      wr_en        = 1'b0;
      wr_line      = req_line;
      wr_state     = rd_state;
      wr_vec       = rd_vec;
      wr_owner     = rd_owner;
      em_load      = 1'b0;
      em_mask      = req_bit;
      em_kind      = MK_DATA;
      em_line      = req_line;
      em_req       = req_src;
      trk_start    = 1'b0;
      trk_st_kind  = PK_WR_INV;
      trk_st_wait  = '0;
      trk_st_owner = rd_owner;

      if (trk_finish) begin
         // close the waiting transaction
         wr_en    = 1'b1;
         wr_line  = trk_line;
         wr_owner = trk_req;
         em_line  = trk_line;
         em_req   = trk_req;
         em_mask  = node_bit(trk_req);
         case (trk_kind)
            PK_RD_FWD: begin
               wr_state = DS_SHR;
               wr_vec   = node_bit(trk_owner) | node_bit(trk_req);
               wr_owner = trk_owner;
            end
            PK_WR_FWD: begin
               wr_state = DS_EXC;
               wr_vec   = node_bit(trk_req);
            end
            default: begin
               wr_state = DS_EXC;
               wr_vec   = node_bit(trk_req);
               em_load  = 1'b1;
               em_kind  = trk_had ? MK_GRANT : MK_DATA;
            end
         endcase
      end else if (accept) begin
         em_load = 1'b1;
         if (line_busy) begin
            em_kind = MK_RETRY;
         end else begin
            case (rd_state)
               DS_SHR: begin
                  if (!req_wr) begin
                     em_kind = MK_DATA;
                     wr_en   = 1'b1;
                     wr_vec  = rd_vec | req_bit;
                  end else if (others == '0) begin
                     em_kind  = MK_GRANT;
                     wr_en    = 1'b1;
                     wr_state = DS_EXC;
                     wr_vec   = req_bit;
                     wr_owner = req_src;
                  end else if (trk_busy) begin
                     em_kind = MK_RETRY;
                  end else begin
                     em_kind     = MK_INV;
                     em_mask     = others;
                     trk_start   = 1'b1;
                     trk_st_kind = PK_WR_INV;
                     trk_st_wait = others;
                  end
               end
               DS_EXC: begin
                  if (rd_owner == req_src) begin
                     em_kind = req_wr ? MK_GRANT : MK_DATA;
                  end else if (trk_busy) begin
                     em_kind = MK_RETRY;
                  end else begin
                     em_kind      = req_wr ? MK_FWD_WR : MK_FWD_RD;
                     em_mask      = node_bit(rd_owner);
                     trk_start    = 1'b1;
                     trk_st_kind  = req_wr ? PK_WR_FWD : PK_RD_FWD;
                     trk_st_wait  = node_bit(rd_owner);
                     trk_st_owner = rd_owner;
                  end
               end
               default: begin
                  em_kind  = MK_DATA;
                  wr_en    = 1'b1;
                  wr_state = req_wr ? DS_EXC : DS_SHR;
                  wr_vec   = req_bit;
                  wr_owner = req_src;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/dir_home_chk.sv
`timescale 1ns/1ps
module dir_home_chk import dir_home_pkg::*; #(
   parameter int NODES = 4,
   parameter int LINES = 16,
   localparam int NW = $clog2(NODES),
   localparam int LW = $clog2(LINES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [NW-1:0]    req_src,
   input logic [LW-1:0]    req_line,
   input logic             msg_valid,
   input logic             msg_ready,
   input logic [NW-1:0]    msg_dst,
   input logic [2:0]       msg_kind,
   input logic [LW-1:0]    msg_line,
   input logic [NW-1:0]    msg_req,
   input logic             trk_busy,
   input logic [LW-1:0]    trk_line,
   input logic [NODES-1:0] trk_wait
);
   p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_dst) && $stable(msg_kind)
                                  && $stable(msg_line) && $stable(msg_req));

   p_no_req_during_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);

   p_retry_busy_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && trk_busy && req_line == trk_line
      |=> msg_valid && msg_kind == 3'(MK_RETRY) && msg_dst == $past(req_src));

   p_wait_keeps_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trk_busy && trk_wait != '0 |=> trk_busy);

   p_inv_skips_requester_r4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_kind == 3'(MK_INV) |-> msg_dst != msg_req);
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .LINES(LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_src(req_src), .req_line(req_line), .msg_valid(msg_valid),
   .msg_ready(msg_ready), .msg_dst(msg_dst), .msg_kind(msg_kind),
   .msg_line(msg_line), .msg_req(msg_req), .trk_busy(trk_busy),
   .trk_line(trk_line), .trk_wait(trk_wait)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;
   localparam int N  = 4;
   localparam int L  = 4;
   localparam int NW = 2;
   localparam int LW = 2;
   localparam int K_DATA = 0, K_GRANT = 1, K_INV = 2, K_FRD = 3, K_FWR = 4, K_RETRY = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid = 1'b0, req_wr = 1'b0;
   logic [NW-1:0] req_src = '0;
   logic [LW-1:0] req_line = '0;
   logic          req_ready;
   logic          ack_valid = 1'b0;
   logic [NW-1:0] ack_src = '0;
   logic [LW-1:0] ack_line = '0;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [NW-1:0] msg_dst, msg_req;
   logic [2:0]    msg_kind;
   logic [LW-1:0] msg_line;

   dir_home_ctrl #(.NODES(N), .LINES(L)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_line(req_line), .req_wr(req_wr),
      .ack_valid(ack_valid), .ack_src(ack_src), .ack_line(ack_line),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dst(msg_dst),
      .msg_kind(msg_kind), .msg_line(msg_line), .msg_req(msg_req)
   );

   int n_chk = 0, n_bad = 0;

   // record every transferred message
   int qn = 0;
   int qd [2048], qk [2048], ql [2048], qr [2048];
   always @(negedge clk) begin
      #1;
      if (msg_valid && msg_ready) begin
         qd[qn % 2048] = int'(msg_dst);
         qk[qn % 2048] = int'(msg_kind);
         ql[qn % 2048] = int'(msg_line);
         qr[qn % 2048] = int'(msg_req);
         qn++;
      end
   end

   // expected message list
   int en = 0;
   int ed [16], ek [16], el [16], er [16];

   // directory model: 0 uncached, 1 shared, 2 exclusive
   int       m_st [L];
   bit [N-1:0] m_vec [L];
   int       m_own [L];
   bit       p_busy = 0;
   int       p_line, p_req, p_own, p_kind, p_had;
   bit [N-1:0] p_wait;

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic push(input int d, input int k, input int r, input int ln);
      ed[en] = d; ek[en] = k; er[en] = r; el[en] = ln; en++;
   endtask

   task automatic expect_msgs(input string tag, input int s0);
      chk({tag, " msg count"}, qn - s0, en);
      for (int i = 0; i < en && i < qn - s0; i++) begin
         chk({tag, " dst"},  qd[(s0 + i) % 2048], ed[i]);
         chk({tag, " kind"}, qk[(s0 + i) % 2048], ek[i]);
         chk({tag, " req"},  qr[(s0 + i) % 2048], er[i]);
         chk({tag, " line"}, ql[(s0 + i) % 2048], el[i]);
      end
   endtask

   task automatic predict(input int s, input int ln, input bit wr);
      bit [N-1:0] oth;
      en = 0;
      if (p_busy && p_line == ln) begin
         push(s, K_RETRY, s, ln);
      end else if (m_st[ln] == 0) begin
         push(s, K_DATA, s, ln);
         m_st[ln] = wr ? 2 : 1; m_vec[ln] = N'(1 << s); m_own[ln] = s;
      end else if (m_st[ln] == 1) begin
         oth = m_vec[ln] & ~N'(1 << s);
         if (!wr) begin
            push(s, K_DATA, s, ln);
            m_vec[ln] = m_vec[ln] | N'(1 << s);
         end else if (oth == 0) begin
            push(s, K_GRANT, s, ln);
            m_st[ln] = 2; m_vec[ln] = N'(1 << s); m_own[ln] = s;
         end else if (p_busy) begin
            push(s, K_RETRY, s, ln);
         end else begin
            for (int n = 0; n < N; n++) if (oth[n]) push(n, K_INV, s, ln);
            p_busy = 1; p_line = ln; p_req = s; p_kind = 2;
            p_wait = oth; p_had = int'(m_vec[ln][s]); p_own = m_own[ln];
         end
      end else begin
         if (m_own[ln] == s) begin
            push(s, wr ? K_GRANT : K_DATA, s, ln);
         end else if (p_busy) begin
            push(s, K_RETRY, s, ln);
         end else begin
            push(m_own[ln], wr ? K_FWR : K_FRD, s, ln);
            p_busy = 1; p_line = ln; p_req = s; p_kind = wr ? 1 : 0;
            p_wait = N'(1 << m_own[ln]); p_had = 0; p_own = m_own[ln];
         end
      end
   endtask

   task automatic txn(input string tag, input int s, input int ln, input bit wr);
      int s0;
      s0 = qn;
      predict(s, ln, wr);
      @(negedge clk);
      req_valid = 1'b1; req_src = NW'(s); req_line = LW'(ln); req_wr = wr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (en + 3) @(negedge clk);
      expect_msgs(tag, s0);
   endtask

   task automatic send_ack(input string tag, input int n, input int ln);
      int s0;
      s0 = qn;
      en = 0;
      if (p_busy && p_line == ln) p_wait[n] = 1'b0;
      if (p_busy && p_wait == 0) begin
         if (p_kind == 0) begin
            m_st[p_line] = 1; m_vec[p_line] = N'((1 << p_own) | (1 << p_req));
         end else begin
            m_st[p_line] = 2; m_vec[p_line] = N'(1 << p_req); m_own[p_line] = p_req;
            if (p_kind == 2) push(p_req, p_had ? K_GRANT : K_DATA, p_req, p_line);
         end
         p_busy = 0;
      end
      @(negedge clk);
      ack_valid = 1'b1; ack_src = NW'(n); ack_line = LW'(ln);
      @(negedge clk);
      ack_valid = 1'b0;
      repeat (4) @(negedge clk);
      expect_msgs(tag, s0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R12 watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit [15:0] r;
      for (int i = 0; i < L; i++) begin m_st[i] = 0; m_vec[i] = '0; m_own[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset req_ready", int'(req_ready), 1);
      chk("R1 reset msg_valid", int'(msg_valid), 0);

      // readers build a shared line, then a third node upgrades it
      txn("R1 R2 first read", 1, 0, 1'b0);
      txn("R2 second reader", 2, 0, 1'b0);
      txn("R4 invalidates", 3, 0, 1'b1);
      txn("R10 busy line retry", 0, 0, 1'b0);
      txn("R11 other line served", 0, 1, 1'b0);
      txn("R6 sole reader upgrade", 0, 1, 1'b1);
      txn("R11 second wait refused", 1, 1, 1'b0);
      send_ack("R13 ack unawaited node", 3, 0);
      send_ack("R13 ack wrong line", 1, 2);
      send_ack("R5 partial acks", 1, 0);
      send_ack("R5 grant after last ack", 2, 0);
      // forwarded read then forwarded write
      txn("R7 forward read", 1, 1, 1'b0);
      send_ack("R7 owner ack", 0, 1);
      txn("R7 shared pair invalidated", 3, 1, 1'b1);
      send_ack("R7 ack a", 0, 1);
      send_ack("R5 ack b", 1, 1);
      txn("R8 forward write", 0, 1, 1'b1);
      send_ack("R8 owner ack", 3, 1);
      txn("R9 owner write", 0, 1, 1'b1);
      txn("R9 owner read", 0, 1, 1'b0);
      txn("R3 write uncached", 2, 3, 1'b1);

      // backpressure on a multi-invalidate burst
      txn("R2 setup", 0, 2, 1'b0);
      txn("R2 setup", 1, 2, 1'b0);
      begin
         int s0;
         s0 = qn;
         predict(3, 2, 1'b1);
         @(negedge clk);
         msg_ready = 1'b0;
         req_valid = 1'b1; req_src = 2'd3; req_line = 2'd2; req_wr = 1'b1;
         while (!req_ready) @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         repeat (3) @(negedge clk);
         chk("R12 held valid", int'(msg_valid), 1);
         chk("R12 held dst", int'(msg_dst), 0);
         chk("R12 req_ready low", int'(req_ready), 0);
         chk("R12 nothing taken", qn - s0, 0);
         msg_ready = 1'b1;
         repeat (en + 3) @(negedge clk);
         expect_msgs("R4 R12 after release", s0);
      end
      send_ack("R5 bp ack a", 0, 2);
      send_ack("R5 bp ack b", 1, 2);

      // sweep over every state and request shape
      r = 16'hACE1;
      for (int it = 0; it < 500; it++) begin
         int s, ln, w;
         bit [N-1:0] wt;
         r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
         s = int'(r[1:0]); ln = int'(r[3:2]); w = int'(r[4]);
         txn("R2 R3 R4 R6 R7 R8 R9 R11 sweep", s, ln, w[0]);
         if (p_busy) begin
            int pl;
            pl = p_line; wt = p_wait;
            if (r[5]) txn("R10 sweep retry", int'(r[7:6]), pl, r[8]);
            for (int n = 0; n < N; n++)
               if (wt[n]) send_ack("R5 R7 R8 sweep ack", n, pl);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule